// File: doc/BRIEF.md
# General-Purpose I/O Port with Alternate-Function Pin Muxing

This block is an eight-pin general-purpose I/O port for a small microcontroller. Software writes two registers over the internal bus. One holds a per-pin output-enable bit and the other holds a per-pin output value. A read strobe returns the pin levels after a two-flop synchronizer. Toward the pads the block drives three vectors per pin: output enable, output value and pull-up enable.

Each pin can also be taken over by an on-chip peripheral. When the two-wire display-data interface is enabled, it claims pins 0 and 1. Pins 2 to 6 each follow their own PWM enable. Pin 7 can be claimed by a PWM channel or by a clamp-pulse generator, and the PWM channel wins when both are enabled. Pins 0 and 1 are open-drain with no pull-up. Pins 2 to 7 are push-pull, and their pull-up is on whenever they are plain inputs. While a peripheral owns a pin, the register bits for that pin are still written and held, but they do not reach the pad until the peripheral lets go.

Top module: `gpio_altmux_port`

## Requirements
- R1: After reset, every register bit is 0. pad_oe is 8'h00 and pad_do is 8'h00. pad_pu is 8'hFC, meaning the pull-up is on for pins 2 to 7 and off for pins 0 and 1.
- R2: A cycle with ctl_wr high loads bus_wdata into the output-enable register, and a cycle with dat_wr high loads it into the output-value register. Bit i belongs to pin i. Each register keeps its value while its own strobe is low.
- R3: With twi_en low, pin 0 or 1 is open-drain: pad_oe[i] is 1 only when the output-enable bit is 1 and the data bit is 0. pad_do[i] equals the data bit.
- R4: pad_pu[0] and pad_pu[1] are always 0.
- R5: Pins 2 to 7 with no alternate function active are push-pull. pad_oe[i] equals the output-enable bit and pad_do[i] equals the data bit. pad_pu[i] is the inverse of the output-enable bit.
- R6: With twi_en high, pad_oe[0] follows twi_sda_oe, pad_oe[1] follows twi_scl_oe, and pad_do[1:0] is 0.
- R7: For pin k+2 (k = 0..5), if pwm_en[k] is high, then pad_oe is 1, pad_do equals pwm_out[k] and pad_pu is 0.
- R8: If pwm_en[5] is low and clamp_en is high, pin 7 has pad_oe 1, pad_do equal to clamp_out, and pad_pu 0.
- R9: If pwm_en[5] and clamp_en are both high, pad_do[7] equals pwm_out[5].
- R10: Register writes made while a peripheral owns a pin do not change that pin's pad outputs. The written values take effect as soon as the peripheral releases the pin.
- R11: While rd_en is high, rd_data equals pad_in as it was two rising clock edges earlier. While rd_en is low, rd_data is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wdata | input | 8 | Internal bus write data |
| ctl_wr | input | 1 | Write strobe for the output-enable register |
| dat_wr | input | 1 | Write strobe for the output-value register |
| rd_en | input | 1 | Read strobe for the pin levels |
| rd_data | output | 8 | Synchronized pin levels, zero when rd_en is low |
| pad_in | input | 8 | Levels seen at the pads |
| twi_en | input | 1 | Two-wire interface claims pins 0 and 1 |
| twi_sda_oe | input | 1 | Two-wire data line pull-low request |
| twi_scl_oe | input | 1 | Two-wire clock line pull-low request |
| pwm_en | input | 6 | PWM enables for pins 2 to 7 |
| pwm_out | input | 6 | PWM waveforms for pins 2 to 7 |
| clamp_en | input | 1 | Clamp-pulse generator claims pin 7 |
| clamp_out | input | 1 | Clamp-pulse waveform |
| pad_oe | output | 8 | Per-pin output enable toward the pad |
| pad_do | output | 8 | Per-pin output value toward the pad |
| pad_pu | output | 8 | Per-pin pull-up enable toward the pad |

## Verification
The pad outputs are combinational from the register bits and the alternate-function inputs. The bench therefore samples them 1 ns after driving the peripheral inputs at a falling edge, once the preceding register writes have settled. A register write becomes visible after the rising edge on which its strobe is high, so every check that follows a write waits for that edge and samples at the next falling edge. The read path is the only delayed result. A pad change made at a falling edge must still read as the old value after the first rising edge and as the new value after the second, and the bench checks both sides of that boundary.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [0:0] {
    PIN_OPEN_DRAIN = 1'b0,
    PIN_PUSH_PULL  = 1'b1
  } pin_kind_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wdata,
  input  logic         ctl_we,
  input  logic         dat_we,
  output logic [W-1:0] ctl_q,
  output logic [W-1:0] dat_q
);
  logic [W-1:0] ctl_d, dat_d;

  always_comb begin
    ctl_d = ctl_q;
    dat_d = dat_q;
    if (ctl_we) ctl_d = wdata;
    if (dat_we) dat_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dat_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      dat_q <= dat_d;
    end
  end

  a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q == $past(wdata)));
  a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));
  a_r2_dat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> $stable(dat_q));
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] nxt;
    if (s == 0) begin : g_first
      assign nxt = d;
    end else begin : g_rest
      assign nxt = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= nxt;
    end
  end

  assign q = stg[STAGES-1];

  if (STAGES >= 2) begin : g_chk
    a_r11_shift: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (q == $past(stg[STAGES-2])));
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_port_pkg::*;
#(
  parameter pin_kind_e KIND = PIN_PUSH_PULL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic io_oe,
  input  logic io_val,
  input  logic alt_en,
  input  logic alt_oe,
  input  logic alt_val,
  output logic pad_oe,
  output logic pad_do,
  output logic pad_pu
);
  logic io_drive;

  if (KIND == PIN_OPEN_DRAIN) begin : g_od
    // drive only toward low; a 1 releases the line
    assign io_drive = io_oe & ~io_val;
    assign pad_pu   = 1'b0;
  end else begin : g_pp
    assign io_drive = io_oe;
    assign pad_pu   = ~alt_en & ~io_oe;
  end

  always_comb begin
    if (alt_en) begin
      pad_oe = alt_oe;
      pad_do = alt_val;
    end else begin
      pad_oe = io_drive;
      pad_do = io_val;
    end
  end

  if (KIND == PIN_OPEN_DRAIN) begin : g_chk_od
    a_r3_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!alt_en && pad_oe) |-> !pad_do);
  end else begin : g_chk_pp
    a_r5_pullup_only_input: assert property (@(posedge clk) disable iff (!rst_n)
      pad_pu |-> !pad_oe);
  end
endmodule

// File: rtl/gpio_altmux_port.sv
module gpio_altmux_port
  import gpio_port_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int OD_PINS = 2,
  parameter int SYNC_N  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PORT_W-1:0]         bus_wdata,
  input  logic                      ctl_wr,
  input  logic                      dat_wr,
  input  logic                      rd_en,
  output logic [PORT_W-1:0]         rd_data,
  input  logic [PORT_W-1:0]         pad_in,
  input  logic                      twi_en,
  input  logic                      twi_sda_oe,
  input  logic                      twi_scl_oe,
  input  logic [PORT_W-OD_PINS-1:0] pwm_en,
  input  logic [PORT_W-OD_PINS-1:0] pwm_out,
  input  logic                      clamp_en,
  input  logic                      clamp_out,
  output logic [PORT_W-1:0]         pad_oe,
  output logic [PORT_W-1:0]         pad_do,
  output logic [PORT_W-1:0]         pad_pu
);
  localparam int PWM_W = PORT_W - OD_PINS;
  localparam int TOP   = PORT_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [PORT_W-1:0] ctl_q, dat_q, pin_sync;
  logic [PORT_W-1:0] alt_en, alt_oe, alt_val;

  gpio_port_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wdata(bus_wdata),
    .ctl_we(ctl_wr), .dat_we(dat_wr), .ctl_q(ctl_q), .dat_q(dat_q)
  );

  gpio_port_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pad_in), .q(pin_sync)
  );

  assign rd_data = rd_en ? pin_sync : '0;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i < OD_PINS) begin : g_twi
      assign alt_en[i]  = twi_en;
      assign alt_oe[i]  = (i == 0) ? twi_sda_oe : twi_scl_oe;
      assign alt_val[i] = 1'b0;
    end else if (i < TOP) begin : g_pwm
      assign alt_en[i]  = pwm_en[i-OD_PINS];
      assign alt_oe[i]  = 1'b1;
      assign alt_val[i] = pwm_out[i-OD_PINS];
    end else begin : g_pwm_clamp
      // PWM wins over clamp when both are enabled
      assign alt_en[i]  = pwm_en[PWM_W-1] | clamp_en;
      assign alt_oe[i]  = 1'b1;
      assign alt_val[i] = pwm_en[PWM_W-1] ? pwm_out[PWM_W-1] : clamp_out;
    end

    gpio_pin_ctrl #(
      .KIND((i < OD_PINS) ? PIN_OPEN_DRAIN : PIN_PUSH_PULL)
    ) u_pin (
      .clk(clk), .rst_n(rst_int_n),
      .io_oe(ctl_q[i]), .io_val(dat_q[i]),
      .alt_en(alt_en[i]), .alt_oe(alt_oe[i]), .alt_val(alt_val[i]),
      .pad_oe(pad_oe[i]), .pad_do(pad_do[i]), .pad_pu(pad_pu[i])
    );
  end

  a_r9_pwm_over_clamp: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pwm_en[PWM_W-1] && clamp_en) |-> (pad_do[TOP] == pwm_out[PWM_W-1]));
  a_r8_clamp_drives: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pwm_en[PWM_W-1] && clamp_en) |-> (pad_oe[TOP] && pad_do[TOP] == clamp_out));
  a_r6_twi_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    twi_en |-> (pad_oe[0] == twi_sda_oe && pad_oe[1] == twi_scl_oe));
  a_r4_od_no_pullup: assert property (@(posedge clk) disable iff (!rst_int_n)
    pad_pu[OD_PINS-1:0] == '0);
  a_r7_pwm_drives: assert property (@(posedge clk) disable iff (!rst_int_n)
    pwm_en[0] |-> (pad_oe[OD_PINS] && !pad_pu[OD_PINS]));
endmodule

// File: tb/tb_gpio_altmux_port.sv
`timescale 1ns/1ps
module tb_gpio_altmux_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_wdata;
  logic       ctl_wr, dat_wr, rd_en;
  logic [7:0] rd_data, pad_in;
  logic       twi_en, twi_sda_oe, twi_scl_oe;
  logic [5:0] pwm_en, pwm_out;
  logic       clamp_en, clamp_out;
  logic [7:0] pad_oe, pad_do, pad_pu;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_altmux_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .ctl_wr(ctl_wr),
    .dat_wr(dat_wr), .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in),
    .twi_en(twi_en), .twi_sda_oe(twi_sda_oe), .twi_scl_oe(twi_scl_oe),
    .pwm_en(pwm_en), .pwm_out(pwm_out), .clamp_en(clamp_en),
    .clamp_out(clamp_out), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
  );

  // {ctl, dat, {twi_en,sda_oe,scl_oe}, pwm_en, pwm_out, {clamp_en,clamp_out},
  //  exp_oe, exp_do, exp_pu}
  localparam int NV = 8;
  localparam logic [56:0] VEC [NV] = '{
    {8'hFF, 8'h00, 3'b000, 6'h00, 6'h00, 2'b00, 8'hFF, 8'h00, 8'h00}, // R3 R5 drive low
    {8'hFF, 8'hFF, 3'b000, 6'h00, 6'h00, 2'b00, 8'hFC, 8'hFF, 8'h00}, // R3 release, R5 high
    {8'h00, 8'hA5, 3'b000, 6'h00, 6'h00, 2'b00, 8'h00, 8'hA5, 8'hFC}, // R4 R5 inputs
    {8'h0F, 8'h5A, 3'b110, 6'h00, 6'h00, 2'b00, 8'h0D, 8'h58, 8'hF0}, // R6 two-wire
    {8'h00, 8'h00, 3'b000, 6'h3F, 6'h2A, 2'b10, 8'hFC, 8'hA8, 8'h00}, // R7 R9 priority
    {8'h00, 8'hFF, 3'b000, 6'h00, 6'h3F, 2'b11, 8'h80, 8'hFF, 8'h7C}, // R8 clamp high
    {8'h00, 8'hFF, 3'b000, 6'h00, 6'h00, 2'b10, 8'h80, 8'h7F, 8'h7C}, // R8 clamp low
    {8'hFF, 8'hFF, 3'b000, 6'h01, 6'h00, 2'b00, 8'hFC, 8'hFB, 8'h00}  // R7 single pin
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); bus_wdata = v; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); bus_wdata = v; dat_wr = 1'b1;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic alt_idle();
    twi_en = 0; twi_sda_oe = 0; twi_scl_oe = 0;
    pwm_en = '0; pwm_out = '0; clamp_en = 0; clamp_out = 0;
  endtask

  initial begin
    rst_n = 1'b0; bus_wdata = '0; ctl_wr = 0; dat_wr = 0; rd_en = 0;
    pad_in = '0;
    alt_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_en = 1'b1; #1;
    chk("R1", "pad_oe after reset", pad_oe, 8'h00);
    chk("R1", "pad_do after reset", pad_do, 8'h00);
    chk("R1", "pad_pu after reset", pad_pu, 8'hFC);
    chk("R1", "rd_data after reset", rd_data, 8'h00);
    rd_en = 1'b0;

    // R2 with R3..R9 through the vector table
    for (int k = 0; k < NV; k++) begin
      alt_idle();
      wr_ctl(VEC[k][56:49]);
      wr_dat(VEC[k][48:41]);
      {twi_en, twi_sda_oe, twi_scl_oe} = VEC[k][40:38];
      pwm_en  = VEC[k][37:32];
      pwm_out = VEC[k][31:26];
      {clamp_en, clamp_out} = VEC[k][25:24];
      #1;
      chk("R2-table", $sformatf("vec %0d pad_oe", k), pad_oe, VEC[k][23:16]);
      chk("R2-table", $sformatf("vec %0d pad_do", k), pad_do, VEC[k][15:8]);
      chk("R2-table", $sformatf("vec %0d pad_pu", k), pad_pu, VEC[k][7:0]);
    end

    // R10: writes under alternate ownership are held, not applied
    alt_idle();
    wr_ctl(8'h00); wr_dat(8'hFF);
    @(negedge clk);
    twi_en = 1; pwm_en = 6'h3F; pwm_out = 6'h00;
    wr_ctl(8'hFF); wr_dat(8'h00);
    #1;
    chk("R10", "pad_oe while owned", pad_oe, 8'hFC);
    chk("R10", "pad_do while owned", pad_do, 8'h00);
    @(negedge clk);
    twi_en = 0; pwm_en = 6'h00; #1;
    chk("R10", "pad_oe after release", pad_oe, 8'hFF);
    chk("R10", "pad_pu after release", pad_pu, 8'h00);

    // R2: a data write alone leaves the enable register untouched
    wr_dat(8'hFF); #1;
    chk("R2", "pad_oe after data-only write", pad_oe, 8'hFC);

    // R11 read latency of two edges
    @(negedge clk);
    rd_en = 1'b1; pad_in = 8'h3C;
    @(negedge clk); #1;
    chk("R11", "rd_data one edge after change", rd_data, 8'h00);
    @(negedge clk); #1;
    chk("R11", "rd_data two edges after change", rd_data, 8'h3C);
    rd_en = 1'b0; #1;
    chk("R11", "rd_data with rd_en low", rd_data, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule